// File: doc/BRIEF.md
# Linked-Access Reservation Monitor

This block keeps track of load-linked reservations for several hardware contexts that share one memory. Each cycle it can accept one load on a load channel and one store on a store channel. Every operation carries a context number and a physical address. A load-linked records a reservation for its context. Each store is then judged against the reservation table. An ordinary store always goes ahead. A store-conditional goes ahead only when the issuing context still holds a reservation on the same granule.

Any store that goes ahead wipes out every reservation on its granule, whoever owns it. Each context other than the storer that loses a reservation this way gets a one-cycle clear-exclusive pulse. A store-conditional that fails leaves the table exactly as it was.

The table has one slot per context, and each slot has a valid bit. A context therefore holds at most one reservation, and a new load-linked overwrites it in place. The data array, cache coherence and the bus protocol sit outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: Before any comparison, an address is reduced to its reservation granule by dropping its low GRAN_LSB bits. With the default of 4, the granule is 16 bytes, so 0x10C and 0x100 fall in the same granule.
- R2: A load-linked from a context that already holds a reservation replaces that context's granule. The old granule stops being reserved for that context.
- R3: A load-linked (ldValid=1, ldLinked=1) from a context with no reservation creates a reservation holding that context and the load's granule.
- R4: An ordinary store (stCond=0) is always allowed, so stAllow=1.
- R5: A store-conditional succeeds only when its own context (stHasCtx=1, stCtx) holds a reservation on the store's granule. Reservations that other contexts hold on that granule neither help nor hinder it. A store-conditional with stHasCtx=0 always fails.
- R6: The result of a store appears one clock edge after the store is presented. At that point stDone=1, stAllow tells whether the store may proceed, scOk=1 marks a successful store-conditional (0 for a failure or an ordinary store), and clrExcl carries the notifications. When no store was presented, all four outputs are 0.
- R7: A failed store-conditional removes no reservation at all, including the requester's own reservation on another granule.
- R8: An allowed store, whether ordinary or a successful conditional, removes every reservation on its granule, for every context.
- R9: For each reservation that an allowed store removes, bit c of clrExcl pulses for one cycle, where c is the owning context, unless c is the storing context. When stHasCtx=0 the store counts as coming from no context, so every owner is notified.
- R10: When a load-linked and a store arrive in the same cycle, the store is applied first and the load-linked allocation after it. The loading context therefore ends up with a reservation even on the granule just stored to.
- R11: Reset clears every reservation and drives all outputs to 0. A store-conditional issued after reset fails.
- R12: A plain load (ldValid=1, ldLinked=0) has no effect on the reservation table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldValid | input | 1 | A load is presented this cycle |
| ldLinked | input | 1 | The load is a load-linked |
| ldCtx | input | CTX_W | Context of the load |
| ldAddr | input | ADDR_W | Physical address of the load |
| stValid | input | 1 | A store is presented this cycle |
| stCond | input | 1 | The store is a store-conditional |
| stHasCtx | input | 1 | The store carries a valid context |
| stCtx | input | CTX_W | Context of the store |
| stAddr | input | ADDR_W | Physical address of the store |
| stDone | output | 1 | A store result is present (one cycle after the store) |
| stAllow | output | 1 | The store may proceed |
| scOk | output | 1 | Store-conditional success bit |
| clrExcl | output | NUM_CTX | Per-context clear-exclusive pulse |

## Verification
Every result of this block is registered. stDone, stAllow, scOk and clrExcl for a store all appear after exactly one rising edge. A table change made by a load-linked or a store is first visible to a store that arrives in the next cycle. The bench therefore drives one operation pair on a falling edge and samples all four outputs on the following falling edge. Table state is checked only through later store-conditionals and the pulses they cause, because the table is not visible at the ports.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  // Strobes from control to the reservation table for the current cycle
  typedef struct packed {
    logic killEn;   // remove every entry that hits the store granule
    logic allocEn;  // write the load-linked granule into the loader's slot
  } tblStrobe_t;
endpackage

// File: rtl/llsc_table.sv
module llsc_table
  import llsc_pkg::*;
#(
  parameter int NUM_CTX  = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4,
  localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int GRAN_W  = ADDR_W - GRAN_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strobe,
  input  logic [CTX_W-1:0]  ldCtx,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [CTX_W-1:0]  stCtx,
  input  logic              stHasCtx,
  output logic [NUM_CTX-1:0] hitVec,
  output logic              ownHit
);
  logic [GRAN_W-1:0] ldGran, stGran;
  logic [NUM_CTX-1:0] validQ;
  logic [GRAN_W-1:0] granQ [NUM_CTX];

  assign ldGran = ldAddr[ADDR_W-1:GRAN_LSB];
  assign stGran = stAddr[ADDR_W-1:GRAN_LSB];

  for (genvar g = 0; g < NUM_CTX; g++) begin : gSlot
    assign hitVec[g] = validQ[g] && (granQ[g] == stGran);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        granQ[g]  <= '0;
      end else if (strobe.allocEn && (ldCtx == CTX_W'(g))) begin
        // allocation wins over a same-cycle kill: store first, then load-linked
        validQ[g] <= 1'b1;
        granQ[g]  <= ldGran;
      end else if (strobe.killEn && hitVec[g]) begin
        validQ[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    ownHit = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (stHasCtx && (stCtx == CTX_W'(i)) && hitVec[i]) ownHit = 1'b1;
    end
  end

  AST_QUIET_TABLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.killEn && !strobe.allocEn) |=> $stable(validQ)); // R7
  AST_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocEn |=> (validQ[$past(ldCtx)] && granQ[$past(ldCtx)] == $past(ldGran))); // R3
  AST_KILL_CLEARS_GRANULE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.killEn && !strobe.allocEn) |=> ((validQ & $past(hitVec)) == '0)); // R8
endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic               ldLinked,
  input  logic [CTX_W-1:0]   ldCtx,
  input  logic               stValid,
  input  logic               stCond,
  input  logic               stHasCtx,
  input  logic [CTX_W-1:0]   stCtx,
  input  logic [NUM_CTX-1:0] hitVec,
  input  logic               ownHit,
  output tblStrobe_t         strobe,
  output logic               stDone,
  output logic               stAllow,
  output logic               scOk,
  output logic [NUM_CTX-1:0] clrExcl
);
  logic allowNow;
  logic [NUM_CTX-1:0] selfMask, notifyNow;

  assign allowNow = stValid && (!stCond || ownHit);

  always_comb begin
    for (int i = 0; i < NUM_CTX; i++) begin
      selfMask[i] = stHasCtx && (stCtx == CTX_W'(i));
    end
    notifyNow = allowNow ? (hitVec & ~selfMask) : '0;
    strobe.killEn  = allowNow;
    strobe.allocEn = ldValid && ldLinked && (int'(ldCtx) < NUM_CTX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stDone  <= 1'b0;
      stAllow <= 1'b0;
      scOk    <= 1'b0;
      clrExcl <= '0;
    end else begin
      stDone  <= stValid;
      stAllow <= allowNow;
      scOk    <= allowNow && stCond;
      clrExcl <= notifyNow;
    end
  end

  AST_PLAIN_STORE_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && !stCond) |=> (stDone && stAllow && !scOk)); // R4
  AST_SC_OK_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rstN)
    scOk |-> (stAllow && stDone)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stValid |=> (!stDone && !stAllow && clrExcl == '0)); // R6
  AST_CLR_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rstN)
    (clrExcl != '0) |-> stAllow); // R9
  AST_NO_SELF_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stHasCtx) |=> !clrExcl[$past(stCtx)]); // R9
  AST_NO_CTX_SC_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stCond && !stHasCtx) |=> !scOk); // R5
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_CTX  = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4,
  localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic               ldLinked,
  input  logic [CTX_W-1:0]   ldCtx,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  logic               stValid,
  input  logic               stCond,
  input  logic               stHasCtx,
  input  logic [CTX_W-1:0]   stCtx,
  input  logic [ADDR_W-1:0]  stAddr,
  output logic               stDone,
  output logic               stAllow,
  output logic               scOk,
  output logic [NUM_CTX-1:0] clrExcl
);
  tblStrobe_t strobe;
  logic [NUM_CTX-1:0] hitVec;
  logic ownHit;

  llsc_ctrl #(.NUM_CTX(NUM_CTX)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldLinked(ldLinked), .ldCtx(ldCtx),
    .stValid(stValid), .stCond(stCond), .stHasCtx(stHasCtx), .stCtx(stCtx),
    .hitVec(hitVec), .ownHit(ownHit), .strobe(strobe),
    .stDone(stDone), .stAllow(stAllow), .scOk(scOk), .clrExcl(clrExcl)
  );

  llsc_table #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) i_table (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldCtx(ldCtx), .ldAddr(ldAddr), .stAddr(stAddr),
    .stCtx(stCtx), .stHasCtx(stHasCtx),
    .hitVec(hitVec), .ownHit(ownHit)
  );
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 0, ldLinked = 0, stValid = 0, stCond = 0, stHasCtx = 0;
  logic [1:0] ldCtx = '0, stCtx = '0;
  logic [31:0] ldAddr = '0, stAddr = '0;
  logic stDone, stAllow, scOk;
  logic [NCTX-1:0] clrExcl;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.NUM_CTX(NCTX), .ADDR_W(32), .GRAN_LSB(4)) i_llsc_monitor (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldLinked(ldLinked), .ldCtx(ldCtx), .ldAddr(ldAddr),
    .stValid(stValid), .stCond(stCond), .stHasCtx(stHasCtx), .stCtx(stCtx), .stAddr(stAddr),
    .stDone(stDone), .stAllow(stAllow), .scOk(scOk), .clrExcl(clrExcl)
  );

  typedef struct packed {
    logic ldV; logic ldL; logic [1:0] ldC; logic [15:0] ldA;
    logic stV; logic stC; logic stH; logic [1:0] stCx; logic [15:0] stA;
    logic expAl; logic expSc; logic [3:0] expClr;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,'h100, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3 LL c0
    '{0,0,0,'h000, 1,1,1,0,'h10C, 1,1,4'b0000, 1},   // R1 R5 R6 same granule SC ok
    '{0,0,0,'h000, 1,1,1,0,'h100, 0,0,4'b0000, 8},   // R8 own SC removed it
    '{1,1,1,'h100, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3 LL c1
    '{1,1,2,'h100, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3 LL c2
    '{1,1,1,'h200, 0,0,0,0,'h000, 0,0,4'b0000, 2},   // R2 c1 moves
    '{0,0,0,'h000, 1,1,1,1,'h100, 0,0,4'b0000, 2},   // R2 old granule gone
    '{0,0,0,'h000, 1,1,1,1,'h200, 1,1,4'b0000, 5},   // R5 R7 failed SC kept c1
    '{1,1,1,'h100, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3
    '{0,0,0,'h000, 1,0,1,3,'h104, 1,0,4'b0110, 9},   // R4 R8 R9 plain store kills c1,c2
    '{0,0,0,'h000, 1,1,1,2,'h100, 0,0,4'b0000, 8},   // R8 c2 killed
    '{1,0,3,'h200, 0,0,0,0,'h000, 0,0,4'b0000, 12},  // R12 plain load
    '{0,0,0,'h000, 1,1,1,3,'h200, 0,0,4'b0000, 12},  // R12 no reservation made
    '{1,1,0,'h100, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3
    '{1,1,2,'h200, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3
    '{0,0,0,'h000, 1,1,1,0,'h200, 0,0,4'b0000, 7},   // R5 R7 c0 SC on c2's granule fails
    '{0,0,0,'h000, 1,1,1,0,'h100, 1,1,4'b0000, 7},   // R7 c0 reservation survived
    '{1,1,3,'h200, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3
    '{0,0,0,'h000, 1,0,0,2,'h208, 1,0,4'b1100, 9},   // R9 no context: all owners told
    '{1,1,1,'h100, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3
    '{1,1,1,'h104, 1,0,1,2,'h100, 1,0,4'b0010, 10},  // R10 store then LL same cycle
    '{0,0,0,'h000, 1,1,1,1,'h100, 1,1,4'b0000, 10},  // R10 c1 holds it again
    '{1,1,0,'h300, 0,0,0,0,'h000, 0,0,4'b0000, 3},   // R3
    '{0,0,0,'h000, 1,1,0,0,'h300, 0,0,4'b0000, 5},   // R5 SC without context fails
    '{0,0,0,'h000, 1,1,1,0,'h300, 1,1,4'b0000, 5}    // R5 R7 still reserved
  };

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {done,allow,sc,clr} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ldValid = v.ldV; ldLinked = v.ldL; ldCtx = v.ldC; ldAddr = 32'(v.ldA);
    stValid = v.stV; stCond = v.stC; stHasCtx = v.stH; stCtx = v.stCx; stAddr = 32'(v.stA);
  endtask

  function automatic vec_t mk(input logic ldV, input logic [1:0] ldC, input logic [15:0] ldA,
                              input logic stV, input logic stC, input logic stH,
                              input logic [1:0] stCx, input logic [15:0] stA);
    vec_t v;
    v = '0;
    v.ldV = ldV; v.ldL = ldV; v.ldC = ldC; v.ldA = ldA;
    v.stV = stV; v.stC = stC; v.stH = stH; v.stCx = stCx; v.stA = stA;
    return v;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {stDone, stAllow, scOk, clrExcl}, 7'b0);
    rstN = 1'b1;
    drive(mk(0, 0, 0, 1, 1, 1, 0, 'h100));
    @(negedge clk);
    check("R11 SC after reset", {stDone, stAllow, scOk, clrExcl}, {1'b1, 1'b0, 1'b0, 4'b0});

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[k].req, k), {stDone, stAllow, scOk, clrExcl},
            {VECS[k].stV, VECS[k].expAl, VECS[k].expSc, VECS[k].expClr});
    end

    // R11: reservation made before a reset does not survive it
    drive(mk(1, 0, 'h400, 0, 0, 0, 0, 0));
    @(negedge clk);
    drive(mk(0, 0, 0, 0, 0, 0, 0, 0));
    rstN = 1'b0;
    @(negedge clk);
    check("R11 outputs during reset", {stDone, stAllow, scOk, clrExcl}, 7'b0);
    rstN = 1'b1;
    drive(mk(0, 0, 0, 1, 1, 1, 0, 'h400));
    @(negedge clk);
    check("R11 SC after mid-run reset", {stDone, stAllow, scOk, clrExcl}, {1'b1, 1'b0, 1'b0, 4'b0});

    // R6: idle cycle after a store clears all outputs
    drive(mk(0, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    check("R6 idle outputs", {stDone, stAllow, scOk, clrExcl}, 7'b0);

    finish_run();
  end
endmodule